// File: doc/BRIEF.md
# Windowed Address Bridge with Posted Writes

This block passes memory requests in one direction, from an upstream request bus to a downstream request bus. It claims only the upstream requests whose address lies inside a programmable window. The window size is a power of two and its base is aligned to that size. In pass-through mode a claimed address goes downstream unchanged. In relocating mode the bridge keeps the offset inside the window and places it on a separately programmed downstream base, so the two sides can lay out their address spaces independently.

Writes are posted. A claimed write completes upstream in the same cycle it is offered, as long as the eight-entry posting buffer has room. The buffer then drains downstream one entry per accepted cycle. Consecutive write beats form a burst. A burst is cut short by a full buffer or by a programmable beat limit, whichever comes first. Reads are single-word and stall upstream. A read waits until every earlier posted write has left the buffer, then goes downstream, and completes upstream only after the downstream side returns the data.

A controller with five named states sequences the read path:
- IDLE: accepts posted writes. A claimed read takes the transition *read-claim* to DRAIN.
- DRAIN: waits; *buffer-empty* moves it to RD_REQ.
- RD_REQ: presents the read downstream; *read-accepted* (ds_ready) moves it to RD_WAIT.
- RD_WAIT: waits; *data-returned* (ds_rvalid) captures the data and moves it to RD_DONE.
- RD_DONE: raises us_ready with the data for one cycle; *respond* returns to IDLE.

Top module: `window_bridge`

## Requirements
- R1: A request is claimed (us_claim=1) only when us_valid=1 and us_addr with its low size-exponent bits cleared equals the effective upstream base. An unclaimed request never gets us_ready and produces no downstream transfer.
- R2: With cfg mode bit 0 = 0 (pass-through), the downstream address of a claimed request equals the upstream address.
- R3: With mode bit 0 = 1 (relocating), the downstream address is the effective downstream base OR'd with the low size-exponent bits of the upstream address, which is upstream address − upstream base + downstream base.
- R4: Both programmed bases are used with their low size-exponent bits cleared. A size exponent written above AW is clamped to AW, which makes the window the whole address space.
- R5: In IDLE, with buffer space available, a claimed write sees us_ready=1 in the same cycle it is offered, whatever ds_ready is doing.
- R6: The posting buffer holds DEPTH (8) entries. While it is full a write gets us_ready=0, and it never holds more than DEPTH entries.
- R7: With latency limit L≠0, at most L write beats are accepted in consecutive cycles, followed by one cycle with us_ready=0. L=0 means no limit.
- R8: Posted writes appear downstream in acceptance order. A read is presented downstream only after the buffer is empty. A downstream request held with ds_ready=0 keeps its address stable.
- R9: A read raises us_ready for exactly one cycle, the cycle after ds_rvalid, with us_rdata equal to ds_rdata. With W writes pending when the read is offered, ds_ready=1 and downstream data returned D cycles after the read is accepted, us_ready appears max(W,1)+2+D cycles after the read is offered. Only one downstream read is outstanding at a time.
- R10: Configuration is written with cfg_we=1 and cfg_sel selecting the register: 0 = size exponent, 1 = upstream base, 2 = downstream base, 3 = mode (bit 0), 4 = latency limit.
- R11: After reset the window is 2^RST_SIZE bytes (1 MB by default) at base 0, the bridge is in pass-through mode with no latency limit, and the buffer is empty with us_ready=0 and ds_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | AW | Configuration write data |
| us_valid | input | 1 | Upstream request valid |
| us_write | input | 1 | Upstream request is a write |
| us_addr | input | AW | Upstream byte address |
| us_wdata | input | DW | Upstream write data |
| us_claim | output | 1 | Request falls inside the window |
| us_ready | output | 1 | Upstream completion: write accepted, or read data valid |
| us_rdata | output | DW | Read data returned upstream |
| ds_valid | output | 1 | Downstream request valid |
| ds_write | output | 1 | Downstream request is a write |
| ds_addr | output | AW | Downstream (translated) address |
| ds_wdata | output | DW | Downstream write data |
| ds_ready | input | 1 | Downstream accepts the request |
| ds_rvalid | input | 1 | Downstream read data valid |
| ds_rdata | input | DW | Downstream read data |

## Verification
A wrong decode or a wrong alignment mask shows up on the first downstream transfer as a wrong ds_addr, or as an out-of-window request that is claimed. A miscounted buffer occupancy or burst counter shows up within one burst as us_ready high or low on the wrong beat. A controller that leaves DRAIN too early puts a read on ds_addr ahead of a posted write, so the order of the downstream log exposes it. A wrong transition anywhere on the read path moves the cycle in which us_ready rises away from the exact stall count predicted by the pending-write count and the downstream delay.

// File: rtl/wbr_pkg.sv
`timescale 1ns/1ps
package wbr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_RD_DONE
    } brg_state_t;

    localparam logic [2:0] SEL_SIZE   = 3'd0;
    localparam logic [2:0] SEL_UPBASE = 3'd1;
    localparam logic [2:0] SEL_DNBASE = 3'd2;
    localparam logic [2:0] SEL_MODE   = 3'd3;
    localparam logic [2:0] SEL_LAT    = 3'd4;
endpackage

// File: rtl/wbr_cfg.sv
`timescale 1ns/1ps
module wbr_cfg #(
    parameter int AW       = 32,
    parameter int LW       = 8,
    parameter int RST_SIZE = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] win_mask,
    output logic [AW-1:0] up_base_eff,
    output logic [AW-1:0] dn_base_eff,
    output logic          nt_mode,
    output logic [LW-1:0] lat_limit
);
    import wbr_pkg::*;
    localparam int SZW = $clog2(AW + 1);

    logic [SZW-1:0] size_q;
    logic [AW-1:0]  up_q, dn_q;
    logic           nt_q;
    logic [LW-1:0]  lat_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= SZW'(RST_SIZE);
            up_q   <= '0;
            dn_q   <= '0;
            nt_q   <= 1'b0;
            lat_q  <= '0;
        end else if (cfg_we) begin
            unique case (cfg_sel)
                SEL_SIZE:   size_q <= (cfg_wdata > AW'(AW)) ? SZW'(AW) : cfg_wdata[SZW-1:0];
                SEL_UPBASE: up_q   <= cfg_wdata;
                SEL_DNBASE: dn_q   <= cfg_wdata;
                SEL_MODE:   nt_q   <= cfg_wdata[0];
                SEL_LAT:    lat_q  <= cfg_wdata[LW-1:0];
                default:    ;
            endcase
        end
    end

    // a shift by AW leaves zero, so the mask then covers every bit
    assign win_mask    = ~({AW{1'b1}} << size_q);
    assign up_base_eff = up_q & ~win_mask;
    assign dn_base_eff = dn_q & ~win_mask;
    assign nt_mode     = nt_q;
    assign lat_limit   = lat_q;
endmodule

// File: rtl/wbr_xlate.sv
`timescale 1ns/1ps
module wbr_xlate #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] win_mask,
    input  logic [AW-1:0] up_base,
    input  logic [AW-1:0] dn_base,
    input  logic          nt_mode,
    output logic          hit,
    output logic [AW-1:0] xaddr
);
    always_comb begin
        hit   = ((addr & ~win_mask) == up_base);
        xaddr = nt_mode ? (dn_base | (addr & win_mask)) : addr;
    end
endmodule

// File: rtl/wbr_postbuf.sv
`timescale 1ns/1ps
module wbr_postbuf #(
    parameter int W     = 64,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] pdata,
    input  logic         pop,
    output logic [W-1:0] qdata,
    output logic         empty,
    output logic         full,
    output logic [$clog2(DEPTH):0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH) + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= bump(wp);
            if (pop)  rp <= bump(rp);
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= pdata;
    end

    assign qdata = mem[rp];
    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
    assign count = cnt;
endmodule

// File: rtl/window_bridge.sv
`timescale 1ns/1ps
module window_bridge #(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int DEPTH    = 8,
    parameter int LW       = 8,
    parameter int RST_SIZE = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          us_valid,
    input  logic          us_write,
    input  logic [AW-1:0] us_addr,
    input  logic [DW-1:0] us_wdata,
    output logic          us_claim,
    output logic          us_ready,
    output logic [DW-1:0] us_rdata,
    output logic          ds_valid,
    output logic          ds_write,
    output logic [AW-1:0] ds_addr,
    output logic [DW-1:0] ds_wdata,
    input  logic          ds_ready,
    input  logic          ds_rvalid,
    input  logic [DW-1:0] ds_rdata
);
    import wbr_pkg::*;
    localparam int EW = AW + DW;
    localparam int CW = $clog2(DEPTH) + 1;

    brg_state_t state, nxt;

    logic [AW-1:0] win_mask, up_base_eff, dn_base_eff, xaddr;
    logic          nt_mode, hit;
    logic [LW-1:0] cfg_lat, bcnt;
    logic          lat_stop, wr_go, buf_pop;
    logic          buf_empty, buf_full;
    logic [CW-1:0] buf_count;
    logic [EW-1:0] buf_q;
    logic [DW-1:0] rdata_q;

    wbr_cfg #(.AW(AW), .LW(LW), .RST_SIZE(RST_SIZE)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .win_mask(win_mask), .up_base_eff(up_base_eff),
        .dn_base_eff(dn_base_eff), .nt_mode(nt_mode), .lat_limit(cfg_lat)
    );

    wbr_xlate #(.AW(AW)) u_xlate (
        .addr(us_addr), .win_mask(win_mask), .up_base(up_base_eff),
        .dn_base(dn_base_eff), .nt_mode(nt_mode), .hit(hit), .xaddr(xaddr)
    );

    wbr_postbuf #(.W(EW), .DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n), .push(wr_go), .pdata({xaddr, us_wdata}),
        .pop(buf_pop), .qdata(buf_q), .empty(buf_empty), .full(buf_full),
        .count(buf_count)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (us_valid && !us_write && hit) nxt = ST_DRAIN;
            ST_DRAIN:   if (buf_empty) nxt = ST_RD_REQ;
            ST_RD_REQ:  if (ds_ready)  nxt = ST_RD_WAIT;
            ST_RD_WAIT: if (ds_rvalid) nxt = ST_RD_DONE;
            ST_RD_DONE: nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        lat_stop = (cfg_lat != '0) && (bcnt == cfg_lat);
        wr_go    = (state == ST_IDLE) && us_valid && us_write && hit
                   && !buf_full && !lat_stop;
        us_claim = us_valid && hit;
        us_ready = wr_go || (state == ST_RD_DONE);
        us_rdata = rdata_q;
        ds_valid = (state == ST_RD_REQ) || !buf_empty;
        ds_write = (state != ST_RD_REQ);
        ds_addr  = (state == ST_RD_REQ) ? xaddr : buf_q[EW-1:DW];
        ds_wdata = buf_q[DW-1:0];
        buf_pop  = !buf_empty && ds_ready;
    end

    // burst beat counter and read data holding register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt    <= '0;
            rdata_q <= '0;
        end else begin
            bcnt <= wr_go ? bcnt + 1'b1 : '0;
            if (state == ST_RD_WAIT && ds_rvalid) rdata_q <= ds_rdata;
        end
    end
endmodule

// File: rtl/wbr_checker.sv
`timescale 1ns/1ps
module wbr_checker #(
    parameter int AW    = 32,
    parameter int LW    = 8,
    parameter int DEPTH = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          us_valid,
    input logic          us_write,
    input logic          us_claim,
    input logic          us_ready,
    input logic          ds_valid,
    input logic          ds_write,
    input logic          ds_ready,
    input logic [AW-1:0] ds_addr,
    input logic          ds_rvalid,
    input logic          buf_empty,
    input logic [$clog2(DEPTH):0] buf_count,
    input logic [LW-1:0] lat_limit
);
    logic [LW:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= (us_valid && us_write && us_ready) ? run_q + 1'b1 : '0;
    end

    assert_ready_needs_claim_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (us_ready && us_write) |-> us_claim);

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        buf_count <= ($clog2(DEPTH)+1)'(DEPTH));

    assert_burst_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_limit != '0) |-> (run_q <= {1'b0, lat_limit}));

    assert_read_after_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_valid && !ds_write) |-> buf_empty);

    assert_ds_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_valid && !ds_ready) |=> (ds_valid && $stable(ds_addr)));

    assert_read_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_valid && !ds_write && ds_ready) |=> !(ds_valid && !ds_write));

    assert_read_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (us_ready && !us_write) |-> $past(ds_rvalid));
endmodule

bind window_bridge wbr_checker #(.AW(AW), .LW(LW), .DEPTH(DEPTH)) u_wbr_checker (
    .clk(clk), .rst_n(rst_n), .us_valid(us_valid), .us_write(us_write),
    .us_claim(us_claim), .us_ready(us_ready), .ds_valid(ds_valid),
    .ds_write(ds_write), .ds_ready(ds_ready), .ds_addr(ds_addr),
    .ds_rvalid(ds_rvalid), .buf_empty(buf_empty), .buf_count(buf_count),
    .lat_limit(cfg_lat)
);

// File: tb/test_window_bridge.sv
`timescale 1ns/1ps
module test_window_bridge;
    logic        clk = 0, rst_n = 0;
    logic        cfg_we = 0;
    logic [2:0]  cfg_sel = 0;
    logic [31:0] cfg_wdata = 0;
    logic        us_valid = 0, us_write = 0;
    logic [31:0] us_addr = 0, us_wdata = 0;
    logic        us_claim, us_ready;
    logic [31:0] us_rdata;
    logic        ds_valid, ds_write;
    logic [31:0] ds_addr, ds_wdata;
    logic        ds_ready = 1;
    logic        ds_rvalid;
    logic [31:0] ds_rdata;

    int nchk = 0, nfail = 0, nlog = 0, rdly = 1, rcnt = 0;
    logic [31:0] log_a [256];
    logic [31:0] log_d [256];
    logic        log_w [256];
    logic [31:0] rresp = 0;

    always #2.5 clk = ~clk;

    window_bridge i_window_bridge (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .us_valid(us_valid), .us_write(us_write),
        .us_addr(us_addr), .us_wdata(us_wdata), .us_claim(us_claim),
        .us_ready(us_ready), .us_rdata(us_rdata), .ds_valid(ds_valid),
        .ds_write(ds_write), .ds_addr(ds_addr), .ds_wdata(ds_wdata),
        .ds_ready(ds_ready), .ds_rvalid(ds_rvalid), .ds_rdata(ds_rdata)
    );

    // downstream log and read responder
    always @(posedge clk) begin
        if (rst_n && ds_valid && ds_ready) begin
            if (nlog < 256) begin
                log_a[nlog] <= ds_addr;
                log_d[nlog] <= ds_wdata;
                log_w[nlog] <= ds_write;
            end
            nlog <= nlog + 1;
        end
        if (rst_n && ds_valid && ds_ready && !ds_write) begin
            rcnt  <= rdly;
            rresp <= ds_addr ^ 32'h5A5A0F0F;
        end else if (rcnt != 0) rcnt <= rcnt - 1;
    end
    assign ds_rvalid = (rcnt == 1);
    assign ds_rdata  = rresp;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        logic [31:0] mask, upb, dnb, addr, off, exp;
        int szs [4] = '{4, 8, 12, 20};
        int wcnt [3] = '{0, 1, 3};
        int n0, k, ew;
        logic r;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state and default 1 MB window at 0
        chk("R11 us_ready after reset", 32'(us_ready), 0);
        chk("R11 ds_valid after reset", 32'(ds_valid), 0);
        us_valid = 1; us_write = 1; us_addr = 32'h000FFFFC;
        #1 chk("R11 default window top claimed", 32'(us_claim), 1);
        us_addr = 32'h00100000;
        #1 chk("R11 default window end unclaimed", 32'(us_claim), 0);
        us_valid = 0;

        // R1 R2 R3 R4 R5 R10 sweep of sizes, modes and offsets with unaligned bases
        ds_ready = 1;
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                cfg(3'd0, szs[s]);
                cfg(3'd1, 32'h9ABCDEF1);
                cfg(3'd2, 32'h13579BDF);
                cfg(3'd3, m);
                mask = (32'h1 << szs[s]) - 1;
                upb  = 32'h9ABCDEF1 & ~mask;
                dnb  = 32'h13579BDF & ~mask;
                for (int o = 0; o < 4; o++) begin
                    off  = (o == 0) ? 0 : (o == 1) ? 1 : (o == 2) ? mask : (mask >> 1);
                    addr = upb | off;
                    exp  = (m == 1) ? (dnb | off) : addr;
                    n0 = nlog;
                    us_valid = 1; us_write = 1; us_addr = addr; us_wdata = addr + 7;
                    #1 chk("R5 write completes at once", 32'(us_ready), 1);
                    @(negedge clk); us_valid = 0;
                    repeat (2) @(negedge clk);
                    chk("R1 one transfer downstream", nlog, n0 + 1);
                    chk(m ? "R3 relocated address" : "R2 pass-through address", log_a[n0], exp);
                end
                // R1 out of window
                n0 = nlog;
                us_valid = 1; us_write = 1; us_addr = upb ^ (32'h1 << szs[s]);
                #1 chk("R1 outside not claimed", {31'b0, us_claim, 1'b0} | 32'(us_ready), 0);
                @(negedge clk); us_valid = 0;
                repeat (2) @(negedge clk);
                chk("R1 outside no downstream transfer", nlog, n0);
            end
        end

        // R4 size clamp: whole space, downstream base masked to zero
        cfg(3'd0, 40); cfg(3'd1, 32'h00001234); cfg(3'd2, 32'hFFFFFFFF); cfg(3'd3, 1);
        n0 = nlog;
        us_valid = 1; us_write = 1; us_addr = 32'hDEADBEE0; us_wdata = 5;
        #1 chk("R4 clamped window claims", 32'(us_claim), 1);
        @(negedge clk); us_valid = 0;
        repeat (2) @(negedge clk);
        chk("R4 clamped window address", log_a[n0], 32'hDEADBEE0);

        // R6 fill the buffer with downstream stalled, R8 order
        cfg(3'd0, 20); cfg(3'd1, 32'h00100000); cfg(3'd3, 0); cfg(3'd4, 0);
        ds_ready = 0;
        @(negedge clk);
        n0 = nlog;
        for (int i = 0; i < 9; i++) begin
            us_valid = 1; us_write = 1; us_addr = 32'h00100000 + 4 * i; us_wdata = i;
            #1 chk(i < 8 ? "R5 posted while downstream stalled" : "R6 full buffer refuses",
                   32'(us_ready), (i < 8) ? 1 : 0);
            @(negedge clk);
        end
        us_valid = 0;
        chk("R8 head held downstream", ds_addr, 32'h00100000);
        ds_ready = 1;
        repeat (10) @(negedge clk);
        chk("R6 eight entries drained", nlog, n0 + 8);
        for (int i = 0; i < 8; i++) begin
            chk("R8 write order address", log_a[n0 + i], 32'h00100000 + 4 * i);
            chk("R8 write order data", log_d[n0 + i], i);
        end

        // R7 latency limit 3, then unlimited
        cfg(3'd4, 3);
        @(negedge clk);
        for (int kk = 0; kk < 12; kk++) begin
            us_valid = 1; us_write = 1; us_addr = 32'h00100010; us_wdata = kk;
            #1 chk("R7 limited burst ready pattern", 32'(us_ready), (kk % 4 != 3) ? 1 : 0);
            @(negedge clk);
        end
        us_valid = 0;
        cfg(3'd4, 0);
        @(negedge clk);
        for (int kk = 0; kk < 12; kk++) begin
            us_valid = 1; us_write = 1; us_addr = 32'h00100010; us_wdata = kk;
            #1 chk("R7 unlimited burst", 32'(us_ready), 1);
            @(negedge clk);
        end
        us_valid = 0;
        repeat (3) @(negedge clk);

        // R8 R9 read stall with pending writes
        for (int d = 1; d <= 3; d += 2) begin
            for (int w = 0; w < 3; w++) begin
                rdly = d;
                ds_ready = 0;
                @(negedge clk);
                n0 = nlog;
                for (int i = 0; i < wcnt[w]; i++) begin
                    us_valid = 1; us_write = 1; us_addr = 32'h00100080 + 4 * i; us_wdata = i;
                    @(negedge clk);
                end
                us_valid = 1; us_write = 0; us_addr = 32'h00100040; ds_ready = 1;
                k = 0;
                r = 0;
                while (!r && k < 60) begin
                    @(negedge clk); k++;
                    #1 r = us_ready;
                end
                us_valid = 0;
                ew = ((wcnt[w] > 1) ? wcnt[w] : 1) + 2 + d;
                chk("R9 read stall cycles", k, ew);
                chk("R9 read data", us_rdata, 32'h00100040 ^ 32'h5A5A0F0F);
                repeat (3) @(negedge clk);
                chk("R9 single read response", 32'(us_ready), 0);
                chk("R8 writes then read downstream", nlog, n0 + wcnt[w] + 1);
                chk("R8 read last downstream", 32'(log_w[n0 + wcnt[w]]), 0);
                if (wcnt[w] > 0)
                    chk("R8 write before read", 32'(log_w[n0 + wcnt[w] - 1]), 1);
            end
        end

        // R1 out-of-window read is ignored
        n0 = nlog;
        us_valid = 1; us_write = 0; us_addr = 32'h00300000;
        for (int i = 0; i < 5; i++) begin
            #1 chk("R1 outside read no ready", {31'b0, us_claim} | 32'(us_ready), 0);
            @(negedge clk);
        end
        us_valid = 0;
        chk("R1 outside read no transfer", nlog, n0);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule